// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the base address registers of one bus function into live address windows and decodes incoming addresses against them. It serves six general regions and one expansion ROM region (index 6). Each region has a power-of-two size, and general regions are typed as I/O or memory. A region's window is derived from its register value, its size and the I/O and memory enable bits of the function's command register. The derivation runs only when a remap pulse arrives. A window that fails a rejection rule is held as an all-ones base and never decodes.

After a remap pulse, a sequencer visits the regions in ascending order, spending two cycles on each. It reports every change of a window as an unmap strobe for the old window, followed one cycle later by a map strobe for the new one. Address lookups can be issued on any cycle and are answered one cycle later from the window table as it stands at that clock edge.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset no window is live, and `hit`, `map_stb` and `unmap_stb` are low.
- R2: A region whose size input is zero never produces a hit or an event.
- R3: An I/O window's base is the register value with the bits below the size cleared. It is live only while `io_enable` was set at the last remap.
- R4: An I/O window is rejected when any of these holds: its base is zero, its last address (base+size-1) is not above the base, or its last address is 0x10000 or higher.
- R5: A memory window is live only while `mem_enable` was set at the last remap. It is rejected when any of these holds: its base is zero, its last address is not above the base, or its last address is all ones.
- R6: Region 6 is the expansion ROM. It is always memory type, and it is rejected whenever bit 0 of its register value is clear.
- R7: Let remap be sampled at clock edge C. Region k is then handled on the two following edges. If its computed base differs from the stored one, an unmap strobe for the old window (when the old window was live) is registered at edge C+2k+1. At edge C+2k+2 the stored base is replaced, and a map strobe is registered if the new window is live. A region whose base is unchanged produces no strobe.
- R8: When `class_code` is 0x0101, the unmap of a 4-byte I/O window is reported as base+2 with size 1. Map strobes are never altered this way.
- R9: A lookup with `req_valid` set is answered on the next edge. The answer gives `hit`, the region index and `hit_is_io`. A region matches only if its type equals `req_is_io`.
- R10: When several live windows contain the address, the lowest-numbered region is reported.
- R11: Changes to register values or enable bits have no effect on decoding until a remap is issued.
- R12: A remap pulse that arrives while a scan is in progress restarts the scan at region 0, with the timing of R7 counted from the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| remap | input | 1 | Pulse that starts a window recomputation scan |
| io_enable | input | 1 | Command register I/O space enable |
| mem_enable | input | 1 | Command register memory space enable |
| class_code | input | 16 | Function class code (base class, subclass) |
| bar_vals | input | NR*AW | Register value of each region, region k at bits k*AW |
| bar_sizes | input | NR*AW | Size of each region (power of two, or zero) |
| bar_is_io | input | NBAR | Type of each general region, 1 = I/O |
| req_valid | input | 1 | Lookup request valid |
| req_is_io | input | 1 | Lookup is in I/O space (1) or memory space (0) |
| req_addr | input | AW | Lookup address |
| hit | output | 1 | Registered lookup hit |
| hit_idx | output | IW | Index of the matching region |
| hit_is_io | output | 1 | Space of the hit |
| map_stb | output | 1 | One-cycle map event |
| unmap_stb | output | 1 | One-cycle unmap event |
| evt_idx | output | IW | Region index of the event |
| evt_base | output | AW | Window base of the event |
| evt_size | output | AW | Window size of the event |
| evt_is_io | output | 1 | Window space of the event |

## Verification
A lookup and a table update can fall in the same cycle, because the table of windows is still changing while the sequencer walks it. The bench provokes this by enabling the ROM window and sending a lookup into that window on every cycle of the scan. It expects a miss for every compare edge up to and including the ROM region's update edge, and a hit afterwards. The scoreboard also orders every map and unmap strobe by the edge on which it is due. This catches a swapped unmap/map order, a wrong restart point and an unmap that is missing.

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int AW = 32,
  parameter int NBAR = 6,
  parameter logic [AW-1:0] IO_LIMIT = 'h10000,
  parameter logic [15:0] IDE_CLASS = 16'h0101,
  localparam int NR = NBAR + 1,
  localparam int IW = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             remap,
  input  logic             io_enable,
  input  logic             mem_enable,
  input  logic [15:0]      class_code,
  input  logic [NR*AW-1:0] bar_vals,
  input  logic [NR*AW-1:0] bar_sizes,
  input  logic [NBAR-1:0]  bar_is_io,
  input  logic             req_valid,
  input  logic             req_is_io,
  input  logic [AW-1:0]    req_addr,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic             hit_is_io,
  output logic             map_stb,
  output logic             unmap_stb,
  output logic [IW-1:0]    evt_idx,
  output logic [AW-1:0]    evt_base,
  output logic [AW-1:0]    evt_size,
  output logic             evt_is_io
);
  localparam logic [AW-1:0] ONES = '1;
  localparam logic [IW-1:0] LAST = IW'(NR - 1);

  logic [AW-1:0] bar_a [NR];
  logic [AW-1:0] size_a [NR];
  logic [NR-1:0] rio;
  logic [AW-1:0] cur [NR];

  for (genvar g = 0; g < NR; g++) begin : g_unpack
    assign bar_a[g]  = bar_vals[g*AW +: AW];
    assign size_a[g] = bar_sizes[g*AW +: AW];
    if (g < NBAR) begin : g_gen
      assign rio[g] = bar_is_io[g];
    end else begin : g_rom
      assign rio[g] = 1'b0;
    end
  end

  function automatic logic [AW-1:0] window(input logic [AW-1:0] bar, input logic [AW-1:0] sz,
                                           input logic io, input logic rom,
                                           input logic ioe, input logic meme);
    logic [AW-1:0] b, l;
    b = bar & ~(sz - 1'b1);
    l = b + sz - 1'b1;
    if (sz == '0) return ONES;
    if (io) begin
      if (!ioe || b == '0 || l <= b || l >= IO_LIMIT) return ONES;
    end else begin
      if (!meme || (rom && !bar[0])) return ONES;
      if (b == '0 || l <= b || l == ONES) return ONES;
    end
    return b;
  endfunction

  logic          busy, phase;
  logic [IW-1:0] idx;
  logic [AW-1:0] nb, ob, osz;
  logic          tio, chg;

  assign tio = rio[idx];
  assign ob  = cur[idx];
  assign osz = size_a[idx];
  assign nb  = window(bar_a[idx], osz, tio, idx == LAST, io_enable, mem_enable);
  assign chg = nb != ob;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      phase <= 1'b0;
      idx <= '0;
      map_stb <= 1'b0;
      unmap_stb <= 1'b0;
      evt_idx <= '0;
      evt_base <= '0;
      evt_size <= '0;
      evt_is_io <= 1'b0;
      for (int r = 0; r < NR; r++) cur[r] <= ONES;
    end else begin
      map_stb <= 1'b0;
      unmap_stb <= 1'b0;
      if (remap) begin
        busy <= 1'b1;
        phase <= 1'b0;
        idx <= '0;
      end else if (busy) begin
        if (!phase) begin
          phase <= 1'b1;
          if (chg && ob != ONES) begin
            unmap_stb <= 1'b1;
            evt_idx <= idx;
            evt_is_io <= tio;
            if (tio && class_code == IDE_CLASS && osz == AW'(4)) begin
              evt_base <= ob + AW'(2);
              evt_size <= AW'(1);
            end else begin
              evt_base <= ob;
              evt_size <= osz;
            end
          end
        end else begin
          phase <= 1'b0;
          cur[idx] <= nb;
          if (chg && nb != ONES) begin
            map_stb <= 1'b1;
            evt_idx <= idx;
            evt_is_io <= tio;
            evt_base <= nb;
            evt_size <= osz;
          end
          if (idx == LAST) busy <= 1'b0;
          else idx <= idx + 1'b1;
        end
      end
    end
  end

  logic          found;
  logic [IW-1:0] fidx;

  always_comb begin
    found = 1'b0;
    fidx = '0;
    for (int r = NR - 1; r >= 0; r--) begin
      if (cur[r] != ONES && rio[r] == req_is_io &&
          (req_addr & ~(size_a[r] - 1'b1)) == cur[r]) begin
        found = 1'b1;
        fidx = IW'(r);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
      hit_idx <= '0;
      hit_is_io <= 1'b0;
    end else begin
      hit <= req_valid && found;
      hit_idx <= (req_valid && found) ? fidx : '0;
      hit_is_io <= req_valid && found && req_is_io;
    end
  end
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
  parameter int AW = 32,
  parameter int NR = 7,
  parameter int IW = 3,
  parameter logic [AW-1:0] IO_LIMIT = 'h10000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          hit,
  input logic [IW-1:0] hit_idx,
  input logic          map_stb,
  input logic          unmap_stb,
  input logic [IW-1:0] evt_idx,
  input logic [AW-1:0] evt_base,
  input logic [AW-1:0] evt_size,
  input logic          evt_is_io
);
  localparam logic [AW-1:0] ONES = '1;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_stb && unmap_stb));

  assert_unmap_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_stb |=> !unmap_stb);

  assert_hit_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(req_valid));

  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(hit_idx) < NR));

  assert_map_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    map_stb |-> (evt_base != '0 && evt_base != ONES));

  assert_io_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_stb && evt_is_io) |-> ((evt_base + evt_size - 1'b1) < IO_LIMIT));

  assert_rom_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((map_stb || unmap_stb) && int'(evt_idx) == NR - 1) |-> !evt_is_io);
endmodule

bind bar_window_decoder bar_window_decoder_chk #(.AW(AW), .NR(NR), .IW(IW), .IO_LIMIT(IO_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit), .hit_idx(hit_idx),
  .map_stb(map_stb), .unmap_stb(unmap_stb), .evt_idx(evt_idx), .evt_base(evt_base),
  .evt_size(evt_size), .evt_is_io(evt_is_io)
);

// File: tb/bar_window_decoder_tb_top.sv
`timescale 1ns/1ps
module bar_window_decoder_tb_top;
  localparam int AW = 32;
  localparam int NR = 7;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic remap = 0, io_enable = 0, mem_enable = 0;
  logic [15:0] class_code = 16'h0;
  logic [NR*AW-1:0] bar_vals, bar_sizes;
  logic [5:0] bar_is_io;
  logic req_valid = 0, req_is_io = 0;
  logic [31:0] req_addr = 0;
  logic hit, hit_is_io, map_stb, unmap_stb, evt_is_io;
  logic [2:0] hit_idx, evt_idx;
  logic [31:0] evt_base, evt_size;

  logic [31:0] tb_bar [NR];
  logic [31:0] tb_size [NR];
  logic [NR-1:0] tb_io;

  always_comb begin
    for (int k = 0; k < NR; k++) begin
      bar_vals[k*AW +: AW] = tb_bar[k];
      bar_sizes[k*AW +: AW] = tb_size[k];
    end
    bar_is_io = tb_io[5:0];
  end

  always #2 clk = ~clk;

  bar_window_decoder dut_i (.*);

  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit is_map; int idx; logic [31:0] base, size; bit io; int due; string tag; } ev_t;
  typedef struct { bit hit; int idx; bit io; int due; string tag; } lk_t;
  ev_t ev_q[$];
  lk_t lk_q[$];

  logic [31:0] old_tab [NR];
  logic [31:0] new_tab [NR];
  int scan_c0 = -1000;

  function automatic logic [31:0] mdl_win(int k);
    logic [31:0] b, l, sz;
    bit io;
    sz = tb_size[k];
    io = (k < 6) && tb_io[k];
    b = tb_bar[k] & ~(sz - 1);
    l = b + sz - 1;
    if (sz == 0) return ONES;
    if (io) begin
      if (!io_enable || b == 0 || l <= b || l >= 32'h10000) return ONES;
    end else begin
      if (!mem_enable || (k == 6 && !tb_bar[k][0])) return ONES;
      if (b == 0 || l <= b || l == ONES) return ONES;
    end
    return b;
  endfunction

  function automatic logic [31:0] exp_base(int k, int e);
    return (e > scan_c0 + 2*k + 2) ? new_tab[k] : old_tab[k];
  endfunction

  task automatic do_remap(string tag);
    int c0;
    @(negedge clk);
    remap = 1;
    c0 = cyc + 1;
    for (int k = 0; k < NR; k++) old_tab[k] = new_tab[k];
    for (int k = 0; k < NR; k++) begin
      logic [31:0] nb;
      bit io;
      nb = mdl_win(k);
      io = (k < 6) && tb_io[k];
      if (nb != old_tab[k]) begin
        if (old_tab[k] != ONES) begin
          if (io && class_code == 16'h0101 && tb_size[k] == 4)
            ev_q.push_back('{0, k, old_tab[k] + 2, 32'd1, io, c0 + 2*k + 1, tag});
          else
            ev_q.push_back('{0, k, old_tab[k], tb_size[k], io, c0 + 2*k + 1, tag});
        end
        if (nb != ONES) ev_q.push_back('{1, k, nb, tb_size[k], io, c0 + 2*k + 2, tag});
      end
      new_tab[k] = nb;
    end
    scan_c0 = c0;
    @(negedge clk);
    remap = 0;
  endtask

  task automatic lookup(bit io, logic [31:0] a, string tag);
    lk_t x;
    int e;
    e = cyc + 1;
    x = '{0, 0, 0, e, tag};
    for (int k = NR - 1; k >= 0; k--) begin
      logic [31:0] b;
      bit rio;
      b = exp_base(k, e);
      rio = (k < 6) && tb_io[k];
      if (b != ONES && rio == io && (a & ~(tb_size[k] - 1)) == b) begin
        x.hit = 1; x.idx = k; x.io = io;
      end
    end
    req_valid = 1; req_is_io = io; req_addr = a;
    lk_q.push_back(x);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    while (ev_q.size() > 0 && ev_q[0].due < cyc) begin
      ev_t m;
      m = ev_q.pop_front();
      check(0, m.tag, "missing event at due cycle", 32'(cyc), 32'(m.due));
    end
    if (map_stb || unmap_stb) begin
      if (ev_q.size() == 0) check(0, "R7", "unexpected event idx", 32'(evt_idx), 32'hFFFF_FFFF);
      else begin
        ev_t m;
        m = ev_q.pop_front();
        check(m.due == cyc, m.tag, "event cycle", 32'(cyc), 32'(m.due));
        check(map_stb == m.is_map && unmap_stb == !m.is_map, m.tag, "event kind (1=map)", 32'(map_stb), 32'(m.is_map));
        check(int'(evt_idx) == m.idx, m.tag, "event idx", 32'(evt_idx), 32'(m.idx));
        check(evt_base == m.base, m.tag, "event base", evt_base, m.base);
        check(evt_size == m.size, m.tag, "event size", evt_size, m.size);
        check(evt_is_io == m.io, m.tag, "event io", 32'(evt_is_io), 32'(m.io));
      end
    end
    if (lk_q.size() > 0 && lk_q[0].due == cyc) begin
      lk_t x;
      x = lk_q.pop_front();
      check(hit == x.hit, x.tag, "hit", 32'(hit), 32'(x.hit));
      if (x.hit) begin
        check(int'(hit_idx) == x.idx, x.tag, "hit_idx", 32'(hit_idx), 32'(x.idx));
        check(hit_is_io == x.io, x.tag, "hit_is_io", 32'(hit_is_io), 32'(x.io));
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) begin
      tb_bar[k] = 0; tb_size[k] = 0; old_tab[k] = ONES; new_tab[k] = ONES;
    end
    tb_io = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!hit && !map_stb && !unmap_stb, "R1", "outputs after reset", {29'b0, hit, map_stb, unmap_stb}, 0);

    io_enable = 1; mem_enable = 1;
    tb_io = 7'b0001101;
    tb_bar[0] = 32'h0000_1234; tb_size[0] = 32'h10;
    tb_bar[1] = 32'h8000_0008; tb_size[1] = 32'h1000;
    tb_bar[2] = 32'h0000_FFF0; tb_size[2] = 32'h20;
    tb_bar[3] = 32'h0001_0000; tb_size[3] = 32'h10;
    tb_bar[4] = 32'h8000_0800; tb_size[4] = 32'h100;
    tb_bar[5] = 32'h9000_0000; tb_size[5] = 0;
    tb_bar[6] = 32'hC000_0000; tb_size[6] = 32'h10000;
    lookup(1, 32'h1235, "R1");
    do_remap("R7");
    idle(16);
    lookup(1, 32'h1235, "R3");
    lookup(0, 32'h1235, "R9");
    lookup(1, 32'hFFFF, "R4");
    lookup(1, 32'h1_0005, "R4");
    lookup(0, 32'h8000_0850, "R10");
    lookup(0, 32'h8000_0F00, "R10");
    lookup(0, 32'h9000_0000, "R2");
    lookup(0, 32'hC000_0000, "R6");

    tb_bar[6] = 32'hC000_0001;
    lookup(0, 32'hC000_1234, "R11");
    do_remap("R6");
    for (int i = 0; i < 16; i++) lookup(0, 32'hC000_0010, "R7");
    idle(2);

    mem_enable = 0;
    lookup(0, 32'h8000_0010, "R11");
    do_remap("R5");
    idle(16);
    lookup(0, 32'h8000_0010, "R5");
    lookup(0, 32'hC000_0010, "R5");

    mem_enable = 1;
    tb_bar[1] = 32'h0;
    tb_bar[4] = 32'hFFFF_FF00;
    do_remap("R5");
    idle(16);
    lookup(0, 32'h0000_0010, "R5");
    lookup(0, 32'hFFFF_FF10, "R5");
    lookup(0, 32'hC000_FFFF, "R6");

    class_code = 16'h0101;
    tb_bar[3] = 32'h0000_0170; tb_size[3] = 4;
    do_remap("R8");
    idle(16);
    lookup(1, 32'h173, "R8");
    io_enable = 0;
    do_remap("R8");
    idle(16);
    lookup(1, 32'h1230, "R3");

    io_enable = 1;
    @(negedge clk); remap = 1;
    @(negedge clk); remap = 0;
    do_remap("R12");
    idle(16);
    lookup(1, 32'h1230, "R12");
    lookup(1, 32'h170, "R12");
    idle(3);

    check(ev_q.size() == 0, "R7", "pending events at end", 32'(ev_q.size()), 0);
    check(lk_q.size() == 0, "R9", "pending lookups at end", 32'(lk_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule